// File: doc/BRIEF.md
# Parallel Test-Mode Compare Logic for a x4 DRAM

This block is a synthesizable behavioural model of the test-mode logic of a four-bit-wide dynamic memory. Multiplexed row and column strobes, write enable, output enable, a shared address bus and a four-bit data path are all sampled on a system clock. The block decodes the strobe ordering of each cycle. It classifies a cycle as one of three kinds: a normal access, a refresh where column strobe comes before row strobe, or a row-strobe-only refresh. From that it switches a parallel test mode on or off.

In normal mode the block behaves as a small x4 array addressed by {row, column}. In test mode the least significant column bit is dropped. Each data pin then maps to a pair of internal bits: the two words whose column addresses differ only in bit 0. A test write copies each pin into both bits of its pair. A test read returns a per-pin agreement flag, so a whole array can be checked at double width. The storage array exists only to make that comparison real. Its size is set by a parameter.

Top module: `dram_ptest`

## Requirements
- R1: After reset the block is in normal mode (test_mode low) and dout_en is low.
- R2: In normal mode, a cycle with row strobe falling while column strobe is high, then column strobe falling, accesses word {row, col}. If write enable is low at the column fall, din is stored. Otherwise the stored nibble appears on dout.
- R3: A refresh cycle with column strobe sampled low at the row strobe fall and write enable low at that same sample enters test mode. If the block is already in test mode, it stays there.
- R4: A refresh cycle with column strobe low and write enable high at the row strobe fall leaves test mode.
- R5: A row-strobe-only cycle (row strobe falls and rises with no column strobe fall between) leaves test mode. Normal read or write cycles never change the mode.
- R6: A test-mode write ignores column bit 0 and stores din into both words {row, col with bit0=0} and {row, col with bit0=1}.
- R7: A test-mode read ignores column bit 0 and drives dout[p] high when bit p of the two paired words is equal, and low when they differ.
- R8: dout_en is high only during a read, while column strobe is still low and output enable is low. A write (write enable low at the column fall) keeps dout_en low for the whole cycle.
- R9: When column and row strobes are first seen low at the same clock edge, the cycle counts as a refresh cycle with column strobe first. It performs no array access and does not alter the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, or per-pin agreement flags in test mode |
| dout_en | output | 1 | Output drive enable |
| test_mode | output | 1 | High while the parallel test mode is active |

## Verification
The mode decoder and the array port can each act on the same edge. The riskiest case is when both strobes are first seen low at one clock edge. The decoder must then treat the cycle as a refresh and must keep the array port from taking a column access. The bench provokes this with directed simultaneous strobe drops, with write enable low and high. It judges the outcome from the test_mode output and from later reads, which must show every word unchanged. Constrained-random traffic then mixes normal accesses, test-mode accesses and both refresh types. A reference array in the bench predicts every read.

// File: rtl/dram_ptest.sv
module dram_ptest #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    din,
  output logic [3:0]    dout,
  output logic          dout_en,
  output logic          test_mode
);
  localparam int DEPTH = 1 << (2*AW);

  logic [3:0]    mem [DEPTH];
  logic          ras_q, cas_q, cyc_cbr, cyc_cas, rd_valid;
  logic [AW-1:0] row_q;
  logic [3:0]    rd_data;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & ~ras_q & ~ras_n & ~cyc_cbr;
  wire [2*AW-1:0] idx    = {row_q, addr};
  wire [2*AW-1:0] idx_lo = {row_q, addr[AW-1:1], 1'b0};
  wire [2*AW-1:0] idx_hi = {row_q, addr[AW-1:1], 1'b1};
  wire [3:0] agree = ~(mem[idx_lo] ^ mem[idx_hi]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      cyc_cbr   <= 1'b0;
      cyc_cas   <= 1'b0;
      rd_valid  <= 1'b0;
      row_q     <= '0;
      rd_data   <= '0;
      test_mode <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        cyc_cbr <= ~cas_n;
        cyc_cas <= 1'b0;
        row_q   <= addr;
        if (!cas_n) test_mode <= ~we_n;
      end
      if (ras_rise && !cyc_cbr && !cyc_cas) test_mode <= 1'b0;
      if (cas_fall) begin
        cyc_cas  <= 1'b1;
        rd_valid <= we_n;
        rd_data  <= test_mode ? agree : mem[idx];
      end else if (cas_n) begin
        rd_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cas_fall && !we_n) begin
      if (test_mode) begin
        mem[idx_lo] <= din;
        mem[idx_hi] <= din;
      end else begin
        mem[idx] <= din;
      end
    end
  end

  assign dout    = rd_data;
  assign dout_en = rd_valid & ~oe_n;
endmodule

// File: rtl/dram_ptest_chk.sv
module dram_ptest_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dout_en,
  input logic test_mode
);
  // R3
  enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n && !we_n |=> test_mode);
  // R4
  leave_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !cas_n && we_n |=> !test_mode);
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ras_n) && !$rose(ras_n) |=> $stable(test_mode));
  // R8
  cas_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |=> !dout_en);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> !test_mode && !dout_en);
endmodule

bind dram_ptest dram_ptest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .dout_en(dout_en), .test_mode(test_mode)
);

// File: tb/dram_ptest_tb.sv
module dram_ptest_tb;
  localparam int AW = 3;
  localparam int DEPTH = 1 << (2*AW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic dout_en, test_mode;

  logic [3:0] ref_mem [DEPTH];
  logic ref_tm = 1'b0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dram_ptest #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .test_mode(test_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
    logic [AW-1:0] c0 = {c[AW-1:1], 1'b0};
    logic [AW-1:0] c1 = {c[AW-1:1], 1'b1};
    if (ref_tm) return ~(ref_mem[{r, c0}] ^ ref_mem[{r, c1}]);
    return ref_mem[{r, c}];
  endfunction

  task automatic access(input logic [AW-1:0] r, input logic [AW-1:0] c,
                        input bit wr, input logic [3:0] d, input bit oe);
    logic [3:0] e;
    @(negedge clk); addr = r; ras_n = 0;
    @(negedge clk); addr = c; we_n = ~wr; din = d; oe_n = ~oe;
    @(negedge clk); cas_n = 0;
    e = exp_read(r, c);
    @(negedge clk);
    if (wr) begin
      chk(dout_en == 0, "R8 write keeps output off", dout_en, 0);
      if (ref_tm) begin
        ref_mem[{r, c[AW-1:1], 1'b0}] = d;
        ref_mem[{r, c[AW-1:1], 1'b1}] = d;
      end else ref_mem[{r, c}] = d;
    end else begin
      chk(dout_en == oe, "R8 read enable", dout_en, oe);
      if (ref_tm) chk(dout == e, "R7 test read flags", dout, e);
      else        chk(dout == e, "R2 normal read", dout, e);
    end
    cas_n = 1; ras_n = 1; we_n = 1;
    @(negedge clk);
    chk(test_mode == ref_tm, "R5 access keeps mode", test_mode, ref_tm);
    chk(dout_en == 0, "R8 off after cycle", dout_en, 0);
  endtask

  task automatic cbr(input bit we_low, input bit same_edge);
    @(negedge clk); cas_n = 0; we_n = ~we_low;
    if (same_edge) ras_n = 0;
    else begin @(negedge clk); ras_n = 0; end
    @(negedge clk);
    ref_tm = we_low;
    if (same_edge) chk(test_mode == ref_tm, "R9 same-edge strobes is refresh", test_mode, ref_tm);
    else if (we_low) chk(test_mode == 1, "R3 enter test mode", test_mode, 1);
    else chk(test_mode == 0, "R4 leave by refresh, we high", test_mode, 0);
    ras_n = 1; cas_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    @(negedge clk); addr = r; ras_n = 0;
    @(negedge clk);
    @(negedge clk); ras_n = 1;
    @(negedge clk);
    ref_tm = 0;
    chk(test_mode == 0, "R5 row-only refresh leaves", test_mode, 0);
  endtask

  task automatic sweep(input string tag);
    bit saved = ref_tm;
    if (saved) ras_only(0);
    for (int i = 0; i < DEPTH; i++) begin
      logic [3:0] e = ref_mem[i];
      @(negedge clk); addr = i[2*AW-1:AW]; ras_n = 0;
      @(negedge clk); addr = i[AW-1:0]; oe_n = 0;
      @(negedge clk); cas_n = 0;
      @(negedge clk);
      chk(dout == e, tag, dout, e);
      cas_n = 1; ras_n = 1;
      @(negedge clk);
    end
    if (saved) cbr(1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(test_mode == 0, "R1 reset mode", test_mode, 0);
    chk(dout_en == 0, "R1 reset output", dout_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk(test_mode == 0, "R1 mode after release", test_mode, 0);

    for (int i = 0; i < DEPTH; i++)
      access(i[2*AW-1:AW], i[AW-1:0], 1, 4'($urandom), 1);
    access(2, 4, 1, 4'hA, 1);
    access(2, 5, 1, 4'h6, 1);
    access(2, 4, 0, 0, 1);
    access(2, 4, 0, 0, 0);

    cbr(1, 0);
    access(2, 5, 0, 0, 1);
    access(2, 4, 0, 0, 1);
    access(3, 3, 1, 4'h9, 1);
    access(3, 2, 0, 0, 1);
    cbr(1, 0);
    chk(test_mode == 1, "R3 re-entry stays", test_mode, 1);
    cbr(0, 0);
    access(3, 2, 0, 0, 1);
    access(3, 3, 0, 0, 1);

    cbr(1, 1);
    sweep("R9 data intact after same-edge refresh");
    cbr(0, 1);
    cbr(1, 0);
    ras_only(5);
    sweep("R9 data intact after refreshes");

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [AW-1:0] r = AW'($urandom);
      logic [AW-1:0] c = AW'($urandom);
      if (op < 4) access(r, c, 0, 0, $urandom_range(0, 3) != 0);
      else if (op < 7) access(r, c, 1, 4'($urandom), 1);
      else if (op == 7) cbr($urandom_range(0, 1), $urandom_range(0, 3) == 0);
      else if (op == 8) ras_only(r);
      else cbr(1, 0);
    end
    sweep("R6 final array contents");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule